// File: doc/BRIEF.md
# Scrolling background tile renderer

This block produces the background layer of a small raster display one pixel at a time. For each view pixel it receives, it adds a frame-wide scroll offset to the pixel's coordinates. This places a 320x240 window on a 640x480 canvas that wraps at both edges. The canvas is divided into 16x16 cells. The renderer reads the attribute word for the cell under the pixel from an external attribute memory. It mirrors the in-cell position when the attribute asks for it. It then reads one row of the selected tile from an external tilemap that holds 1024 tiles. The result is a palette number and a 3-bit colour index.

Both memories are synchronous. The renderer registers an address in one cycle, and the memory returns the word in the next. A new pixel may enter on every clock. The scroll offsets are written through a small register port and are double-buffered. A written value only reaches the rendering path when a frame boundary pulse arrives, so every frame uses a single offset throughout.

Top module: `bgr_tile_renderer`

## Requirements
- R1: After reset, bg_valid, bg_palette, bg_cidx, attr_addr and tile_addr are all zero, and the applied scroll offsets are zero.
- R2: For a pixel (x, y) under applied offsets (sx, sy), the canvas position is cx = (x + sx) mod 640 and cy = (y + sy) mod 480. attr_addr equals (cy / 16) * 40 + cx / 16 in the cycle after the pixel is sampled.
- R3: An attribute word holds the tile number in bits 9..0, the palette in bits 12..10, horizontal mirroring in bit 13 and vertical mirroring in bit 14. bg_palette equals the palette field of the pixel's cell.
- R4: tile_addr equals tile * 16 + r, where r is cy mod 16, or 15 minus that value when bit 14 is set. It is presented three cycles after the pixel is sampled.
- R5: A tilemap word holds one tile row, with column i in bits 3i+2..3i. bg_cidx is column cx mod 16 of that row, or column 15 minus that value when bit 13 is set.
- R6: The result for a pixel sampled at clock edge n is driven after edge n+4 with bg_valid high. One pixel is accepted per cycle. Cycles without pix_valid produce no result, and every accepted pixel yields exactly one result.
- R7: A write with scroll_sel 0 sets the pending horizontal offset to scroll_wdata mod 640. A write with scroll_sel 1 sets the pending vertical offset to (scroll_wdata mod 512) mod 480. Each write leaves the other axis unchanged.
- R8: Pending offsets take effect only for pixels sampled after an edge at which vblank_start is high. Until then, pixels use the previously applied offsets.
- R9: Pixels whose canvas position passes the right or bottom canvas edge wrap to column 0 or row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | A view pixel is presented this cycle |
| pix_x | input | 9 | View column, 0 to 319 |
| pix_y | input | 8 | View row, 0 to 239 |
| vblank_start | input | 1 | Frame boundary pulse that applies the pending offsets |
| scroll_we | input | 1 | Scroll register write strobe |
| scroll_sel | input | 1 | 0 selects horizontal offset, 1 selects vertical |
| scroll_wdata | input | 10 | Offset value to write |
| attr_addr | output | 11 | Attribute memory read address |
| attr_rdata | input | 15 | Attribute word, returned one cycle after the address |
| tile_addr | output | 14 | Tilemap read address (tile, row) |
| tile_rdata | input | 48 | Tile row of sixteen 3-bit colour indices, one cycle after the address |
| bg_valid | output | 1 | Result qualifier |
| bg_palette | output | 3 | Palette number of the pixel |
| bg_cidx | output | 3 | Colour index within the palette |

## Verification
Each result has its own due cycle relative to the edge that samples a pixel. attr_addr changes after that edge, tile_addr after the third, and the colour and palette after the fifth. The bench drives inputs and reads outputs only on falling edges. It reads the two addresses exactly one and three falling edges after driving a pixel. Colour results are compared against a queue of expected values filled at drive time, so each result is matched to its pixel by order and not by wall time. A dedicated scenario counts the falling edges until bg_valid rises. Offset changes are modelled at the exact edge where the design samples vblank_start, so pixels entering before and after that edge are predicted with different offsets.

// File: rtl/bgr_pkg.sv
package bgr_pkg;

  // Canvas and view geometry
  localparam int CANVAS_W   = 640;
  localparam int CANVAS_H   = 480;
  localparam int VIEW_W     = 320;
  localparam int VIEW_H     = 240;
  localparam int TILE_LOG   = 4;
  localparam int TILE_SZ    = 1 << TILE_LOG;

  // Attribute and tilemap formats
  localparam int TILE_IDX_W = 10;
  localparam int PAL_W      = 3;
  localparam int CIDX_W     = 3;

  // Derived sizes
  localparam int GRID_W  = CANVAS_W / TILE_SZ;
  localparam int GRID_H  = CANVAS_H / TILE_SZ;
  localparam int CX_W    = $clog2(CANVAS_W);
  localparam int CY_W    = $clog2(CANVAS_H);
  localparam int VX_W    = $clog2(VIEW_W);
  localparam int VY_W    = $clog2(VIEW_H);
  localparam int SCR_W   = CX_W;
  localparam int ATTR_AW = $clog2(GRID_W * GRID_H);
  localparam int ATTR_DW = TILE_IDX_W + PAL_W + 2;
  localparam int TILE_AW = TILE_IDX_W + TILE_LOG;
  localparam int TILE_DW = TILE_SZ * CIDX_W;

  // Sized wrap limits
  localparam logic [CX_W:0]      CX_WRAP    = (CX_W + 1)'(CANVAS_W);
  localparam logic [CY_W:0]      CY_WRAP    = (CY_W + 1)'(CANVAS_H);
  localparam logic [CX_W-1:0]    CX_LIM     = CX_W'(CANVAS_W);
  localparam logic [CY_W-1:0]    CY_LIM     = CY_W'(CANVAS_H);
  localparam logic [ATTR_AW-1:0] ATTR_CELLS = ATTR_AW'(GRID_W * GRID_H);
  localparam logic [ATTR_AW-1:0] ATTR_ROW   = ATTR_AW'(GRID_W);

  typedef logic [CX_W-1:0]     cx_t;
  typedef logic [CY_W-1:0]     cy_t;
  typedef logic [TILE_LOG-1:0] fine_t;

  typedef struct packed {
    logic                  vflip;
    logic                  hflip;
    logic [PAL_W-1:0]      pal;
    logic [TILE_IDX_W-1:0] idx;
  } attr_t;

  // Canvas column: view column plus offset, folded once at the canvas width
  function automatic cx_t canvas_x(cx_t base, cx_t offs);
    logic [CX_W:0] sum;
    sum = {1'b0, base} + {1'b0, offs};
    if (sum >= CX_WRAP) sum = sum - CX_WRAP;
    return sum[CX_W-1:0];
  endfunction

  // Canvas row: view row plus offset, folded once at the canvas height
  function automatic cy_t canvas_y(cy_t base, cy_t offs);
    logic [CY_W:0] sum;
    sum = {1'b0, base} + {1'b0, offs};
    if (sum >= CY_WRAP) sum = sum - CY_WRAP;
    return sum[CY_W-1:0];
  endfunction

  // Written horizontal offset brought into canvas range
  function automatic cx_t fold_scroll_x(logic [SCR_W-1:0] v);
    cx_t r;
    r = v;
    if (r >= CX_LIM) r = r - CX_LIM;
    return r;
  endfunction

  // Written vertical offset: low bits kept, then brought into canvas range
  function automatic cy_t fold_scroll_y(logic [SCR_W-1:0] v);
    cy_t r;
    r = v[CY_W-1:0];
    if (r >= CY_LIM) r = r - CY_LIM;
    return r;
  endfunction

  // Row-major cell number in the attribute grid
  function automatic logic [ATTR_AW-1:0] cell_index(cx_t cx, cy_t cy);
    logic [ATTR_AW-1:0] row;
    logic [ATTR_AW-1:0] col;
    row = ATTR_AW'(cy >> TILE_LOG);
    col = ATTR_AW'(cx >> TILE_LOG);
    return row * ATTR_ROW + col;
  endfunction

  // Tilemap address of the (possibly mirrored) row within the selected tile
  function automatic logic [TILE_AW-1:0] row_address(attr_t a, fine_t fy);
    return {a.idx, (a.vflip ? ~fy : fy)};
  endfunction

  // Column within the tile row, mirrored when asked
  function automatic fine_t texel_column(attr_t a, fine_t fx);
    return a.hflip ? ~fx : fx;
  endfunction

endpackage

// File: rtl/bgr_scroll_regs.sv
module bgr_scroll_regs
  import bgr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [SCR_W-1:0] wr_data,
  input  logic             frame_load,
  output cx_t              act_x,
  output cy_t              act_y
);

  cx_t  pend_x;
  cy_t  pend_y;
  logic wr_x_evt;
  logic wr_y_evt;
  logic load_evt;

  assign wr_x_evt = wr_en & ~wr_sel;
  assign wr_y_evt = wr_en &  wr_sel;
  assign load_evt = frame_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_x <= '0;
      pend_y <= '0;
      act_x  <= '0;
      act_y  <= '0;
    end else begin
      if (wr_x_evt) pend_x <= fold_scroll_x(wr_data);
      if (wr_y_evt) pend_y <= fold_scroll_y(wr_data);
      if (load_evt) begin
        act_x <= pend_x;
        act_y <= pend_y;
      end
    end
  end

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> ($stable(act_x) && $stable(act_y))); // R8

  AST_PENDING_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_x < CX_LIM) && (pend_y < CY_LIM)); // R7

endmodule

// File: rtl/bgr_attr_stage.sv
module bgr_attr_stage
  import bgr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [VX_W-1:0]    pix_x,
  input  logic [VY_W-1:0]    pix_y,
  input  cx_t                scroll_x,
  input  cy_t                scroll_y,
  output logic [ATTR_AW-1:0] attr_addr,
  output logic               out_valid,
  output fine_t              fine_x,
  output fine_t              fine_y
);

  cx_t cx_w;
  cy_t cy_w;

  assign cx_w = canvas_x(CX_W'(pix_x), scroll_x);
  assign cy_w = canvas_y(CY_W'(pix_y), scroll_y);

  // Address-set step for the attribute read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      attr_addr <= '0;
      out_valid <= 1'b0;
      fine_x    <= '0;
      fine_y    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        attr_addr <= cell_index(cx_w, cy_w);
        fine_x    <= cx_w[TILE_LOG-1:0];
        fine_y    <= cy_w[TILE_LOG-1:0];
      end
    end
  end

  AST_ATTR_IN_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (attr_addr < ATTR_CELLS)); // R2

endmodule

// File: rtl/bgr_texel_stage.sv
module bgr_texel_stage
  import bgr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  fine_t              fine_x,
  input  fine_t              fine_y,
  input  logic [ATTR_DW-1:0] attr_rdata,
  output logic [TILE_AW-1:0] tile_addr,
  input  logic [TILE_DW-1:0] tile_rdata,
  output logic               out_valid,
  output logic [PAL_W-1:0]   out_pal,
  output logic [CIDX_W-1:0]  out_cidx
);

  attr_t attr_w;
  assign attr_w = attr_t'(attr_rdata);

  // Cycle waiting for the attribute word
  logic  wait_v;
  fine_t wait_fx;
  fine_t wait_fy;

  // Cycle with the tile row address registered
  logic             row_v;
  fine_t            row_col;
  logic [PAL_W-1:0] row_pal;

  // Cycle waiting for the tile row word
  logic             word_v;
  fine_t            word_col;
  logic [PAL_W-1:0] word_pal;

  fine_t col_w;
  assign col_w = texel_column(attr_w, wait_fx);

  // Split the tile row into one lane per column
  logic [CIDX_W-1:0] texel_lane [TILE_SZ];
  for (genvar i = 0; i < TILE_SZ; i++) begin : g_lane
    assign texel_lane[i] = tile_rdata[i*CIDX_W +: CIDX_W];
  end

  logic [CIDX_W-1:0] texel_w;
  assign texel_w = texel_lane[word_col];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_v    <= 1'b0;
      wait_fx   <= '0;
      wait_fy   <= '0;
      row_v     <= 1'b0;
      row_col   <= '0;
      row_pal   <= '0;
      tile_addr <= '0;
      word_v    <= 1'b0;
      word_col  <= '0;
      word_pal  <= '0;
      out_valid <= 1'b0;
      out_pal   <= '0;
      out_cidx  <= '0;
    end else begin
      wait_v  <= in_valid;
      wait_fx <= fine_x;
      wait_fy <= fine_y;

      row_v <= wait_v;
      if (wait_v) begin
        tile_addr <= row_address(attr_w, wait_fy);
        row_col   <= col_w;
        row_pal   <= attr_w.pal;
      end

      word_v   <= row_v;
      word_col <= row_col;
      word_pal <= row_pal;

      out_valid <= word_v;
      if (word_v) begin
        out_pal  <= word_pal;
        out_cidx <= texel_w;
      end
    end
  end

  AST_PAL_FROM_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_pal == $past(attr_w.pal, 3))); // R3

endmodule

// File: rtl/bgr_tile_renderer.sv
module bgr_tile_renderer
  import bgr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid,
  input  logic [VX_W-1:0]    pix_x,
  input  logic [VY_W-1:0]    pix_y,
  input  logic               vblank_start,
  input  logic               scroll_we,
  input  logic               scroll_sel,
  input  logic [SCR_W-1:0]   scroll_wdata,
  output logic [ATTR_AW-1:0] attr_addr,
  input  logic [ATTR_DW-1:0] attr_rdata,
  output logic [TILE_AW-1:0] tile_addr,
  input  logic [TILE_DW-1:0] tile_rdata,
  output logic               bg_valid,
  output logic [PAL_W-1:0]   bg_palette,
  output logic [CIDX_W-1:0]  bg_cidx
);

  cx_t   scroll_x_q;
  cy_t   scroll_y_q;
  logic  cell_v;
  fine_t cell_fx;
  fine_t cell_fy;

  bgr_scroll_regs u_scroll (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (scroll_we),
    .wr_sel     (scroll_sel),
    .wr_data    (scroll_wdata),
    .frame_load (vblank_start),
    .act_x      (scroll_x_q),
    .act_y      (scroll_y_q)
  );

  bgr_attr_stage u_attr (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pix_valid),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .scroll_x  (scroll_x_q),
    .scroll_y  (scroll_y_q),
    .attr_addr (attr_addr),
    .out_valid (cell_v),
    .fine_x    (cell_fx),
    .fine_y    (cell_fy)
  );

  bgr_texel_stage u_texel (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (cell_v),
    .fine_x     (cell_fx),
    .fine_y     (cell_fy),
    .attr_rdata (attr_rdata),
    .tile_addr  (tile_addr),
    .tile_rdata (tile_rdata),
    .out_valid  (bg_valid),
    .out_pal    (bg_palette),
    .out_cidx   (bg_cidx)
  );

  AST_RESULT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ##5 bg_valid); // R6

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    bg_valid |-> $past(pix_valid, 5)); // R6

endmodule

// File: tb/test_bgr_tile_renderer.sv
module test_bgr_tile_renderer;
  import bgr_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               pix_valid = 1'b0;
  logic [VX_W-1:0]    pix_x = '0;
  logic [VY_W-1:0]    pix_y = '0;
  logic               vblank_start = 1'b0;
  logic               scroll_we = 1'b0;
  logic               scroll_sel = 1'b0;
  logic [SCR_W-1:0]   scroll_wdata = '0;
  logic [ATTR_AW-1:0] attr_addr;
  logic [ATTR_DW-1:0] attr_rdata = '0;
  logic [TILE_AW-1:0] tile_addr;
  logic [TILE_DW-1:0] tile_rdata = '0;
  logic               bg_valid;
  logic [PAL_W-1:0]   bg_palette;
  logic [CIDX_W-1:0]  bg_cidx;

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int mode = 0;
  int seed = 0;
  string cur_req = "R5";
  int sx_act = 0, sy_act = 0, sx_pend = 0, sy_pend = 0;
  logic [5:0] exp_q [$];
  logic last_valid = 1'b0;
  bit done = 0;

  bgr_tile_renderer i_bgr_tile_renderer (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .vblank_start(vblank_start), .scroll_we(scroll_we), .scroll_sel(scroll_sel),
    .scroll_wdata(scroll_wdata), .attr_addr(attr_addr), .attr_rdata(attr_rdata),
    .tile_addr(tile_addr), .tile_rdata(tile_rdata), .bg_valid(bg_valid),
    .bg_palette(bg_palette), .bg_cidx(bg_cidx)
  );

  // Attribute content: [9:0] tile, [12:10] palette, [13] hflip, [14] vflip
  function automatic logic [14:0] attr_fn(int a);
    int idx, pal;
    bit h, v;
    idx = (a * 37 + seed * 11) % 1024;
    pal = (a + seed) % 8;
    h = (mode == 1) || (mode == 3 && (a % 2) == 1);
    v = (mode == 2) || (mode == 3 && ((a / 2) % 2) == 1);
    return {v, h, 3'(pal), 10'(idx)};
  endfunction

  // Tile row content: column p in bits 3p+2..3p
  function automatic logic [47:0] tile_fn(int addr);
    logic [47:0] w;
    for (int p = 0; p < 16; p++)
      w[p*3 +: 3] = 3'((addr % 16 + (addr / 16) * 3 + p * 5) % 8);
    return w;
  endfunction

  function automatic logic [5:0] expect_pix(int x, int y);
    int cx, cy, a, fx, fy;
    logic [14:0] at;
    logic [47:0] w;
    cx = (x + sx_act) % 640;
    cy = (y + sy_act) % 480;
    a  = (cy / 16) * 40 + cx / 16;
    at = attr_fn(a);
    fx = cx % 16;
    fy = cy % 16;
    if (at[13]) fx = 15 - fx;
    if (at[14]) fy = 15 - fy;
    w = tile_fn(int'(at[9:0]) * 16 + fy);
    return {at[12:10], w[fx*3 +: 3]};
  endfunction

  // Synchronous memories: word returned one cycle after its address
  always @(posedge clk) begin
    attr_rdata <= attr_fn(int'(attr_addr));
    tile_rdata <= tile_fn(int'(tile_addr));
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input int x, input int y,
                      input bit we, input bit sel, input int wd, input bit vb);
    logic [5:0] e;
    @(negedge clk);
    last_valid = bg_valid;
    if (bg_valid) begin
      if (exp_q.size() == 0) check(0, "R6", "result without pixel", 1, 0);
      else begin
        e = exp_q.pop_front();
        check({bg_palette, bg_cidx} == e, cur_req, "pixel {pal,cidx}",
              int'({bg_palette, bg_cidx}), int'(e));
      end
    end
    pix_valid    = v;
    pix_x        = VX_W'(x);
    pix_y        = VY_W'(y);
    scroll_we    = we;
    scroll_sel   = sel;
    scroll_wdata = SCR_W'(wd);
    vblank_start = vb;
    if (v) exp_q.push_back(expect_pix(x, y));
    if (vb) begin sx_act = sx_pend; sy_act = sy_pend; end
    if (we) begin
      if (!sel) sx_pend = wd % 640;
      else      sy_pend = (wd % 512) % 480;
    end
  endtask

  task automatic pix(int x, int y);  step(1, x, y, 0, 0, 0, 0); endtask
  task automatic idle();             step(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr_scroll(bit sel, int val); step(0, 0, 0, 1, sel, val, 0); endtask
  task automatic frame_pulse();      step(0, 0, 0, 0, 0, 0, 1); endtask

  task automatic flush(string req);
    repeat (6) idle();
    check(exp_q.size() == 0, req, "results outstanding", exp_q.size(), 0);
  endtask

  task automatic t_reset();
    check(bg_valid == 0 && bg_palette == 0 && bg_cidx == 0 && attr_addr == 0 && tile_addr == 0,
          "R1", "outputs in reset", int'({bg_valid, bg_palette, bg_cidx}) + int'(attr_addr) + int'(tile_addr), 0);
  endtask

  task automatic t_reset_scroll();
    mode = 0; seed = 1; cur_req = "R1";
    pix(5, 3); pix(300, 200);
    flush("R1");
  endtask

  task automatic t_latency();
    mode = 0; seed = 2; cur_req = "R6";
    pix(10, 10);
    for (int k = 1; k <= 5; k++) begin
      idle();
      check(last_valid == (k == 5), "R6", "bg_valid at falling edge", int'(last_valid), int'(k == 5));
    end
    flush("R6");
  endtask

  task automatic t_addr(int m);
    logic [14:0] at;
    int fy;
    mode = m; seed = 3; cur_req = "R3";
    pix(37, 50);
    idle();
    check(attr_addr == 11'd122, "R2", "attr_addr", int'(attr_addr), 122);
    at = attr_fn(122);
    fy = at[14] ? 15 - 2 : 2;
    idle(); idle();
    check(int'(tile_addr) == int'(at[9:0]) * 16 + fy, "R4", "tile_addr",
          int'(tile_addr), int'(at[9:0]) * 16 + fy);
    flush("R4");
  endtask

  task automatic t_stream(int m, string req);
    mode = m; seed = 4 + m; cur_req = req;
    foreach (rows_list[i]) for (int x = 0; x < 320; x += 3) pix(x, rows_list[i]);
    flush(req);
  endtask

  int rows_list [4] = '{0, 17, 130, 239};

  task automatic t_bubbles();
    mode = 3; seed = 9; cur_req = "R6";
    for (int x = 0; x < 40; x++) begin
      pix(x * 7, x * 5);
      if (x % 3 == 0) idle();
    end
    flush("R6");
  endtask

  task automatic t_scroll();
    mode = 3; seed = 5; cur_req = "R8";
    wr_scroll(0, 100);
    wr_scroll(1, 50);
    pix(20, 20); pix(319, 239);         // still old offsets
    flush("R8");
    frame_pulse();
    pix(20, 20); pix(319, 239);         // new offsets
    flush("R8");
    cur_req = "R7";
    wr_scroll(0, 1000);                 // folds to 360
    wr_scroll(1, 1000);                 // folds to 8
    frame_pulse();
    pix(0, 0); pix(250, 100); pix(319, 239);
    flush("R7");
    wr_scroll(1, 30);                   // vertical only, horizontal stays 360
    frame_pulse();
    pix(1, 1); pix(100, 231);
    flush("R7");
  endtask

  task automatic t_wrap();
    mode = 1; seed = 6; cur_req = "R9";
    wr_scroll(0, 639);
    wr_scroll(1, 479);
    frame_pulse();
    pix(0, 0); pix(1, 1); pix(319, 239); pix(0, 239); pix(319, 0);
    flush("R9");
    wr_scroll(0, 600);
    wr_scroll(1, 400);
    frame_pulse();
    for (int x = 0; x < 320; x += 8) pix(x, 100);
    flush("R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset_scroll();
    t_latency();
    t_addr(0);
    t_addr(2);
    t_stream(0, "R5");
    t_stream(1, "R5");
    t_stream(2, "R4");
    t_stream(3, "R3");
    t_bubbles();
    t_scroll();
    t_wrap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule